// File: doc/BRIEF.md
# Flash command unlock controller

This block guards the command path into a flash array. Software talks to it over a byte-wide register bus, and it starts a flash operation only when a fixed unlock sequence comes first. The sequence is a preset byte written into the data mailbox, then two magic bytes written into two key registers, in that order. Any other write in between, or a wrong key value, drops the sequence, and the command that follows is refused.

An accepted command raises `cpu_hold`, which stalls the processor because there is only one physical flash block. The controller then issues a one-cycle `fl_start` pulse carrying the opcode, the address and the mailbox byte. It waits for the array's one-cycle `fl_done` pulse and then releases the hold. A completion bit in the configuration register tells a command that ran to the end apart from one that was ignored. A read that hits a locked area leaves the mailbox at its previous contents instead of loading array data.

The flash port has no back-pressure. The array must accept `fl_start` in the cycle it is high, and `fl_done` may arrive any number of cycles later, but not in the start cycle. Toward the processor, `cpu_hold` is the only back-pressure: while it is high, every bus write is dropped.

Top module: `fcu_unlock_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enable bit, the completion bit, `cpu_hold`, the unlock sequence and all registers. After reset, the configuration register reads 00H and `cpu_hold` is 0.
- R2: Register offset 0 is the configuration register. Bit 6 is the read/write enable. While bit 6 is 0, a command write never raises `fl_start` or `cpu_hold`, and it sets bit 7 to 0.
- R3: Write 55H to the mailbox (offset 2), then A2H to key 1 (offset 5), then DFH to key 2 (offset 6), then a supported code to the command register (offset 1), with the enable set. In the cycle after the command write, `cpu_hold` rises and `fl_start` is high for exactly one cycle. In that cycle, `fl_op` is the code, `fl_addr` is {offset 4, offset 3} and `fl_wdata` is the mailbox.
- R4: The sequence is cancelled by any write out of order, by any write to another register before the command, or by a wrong key value. The next command is then ignored and bit 7 reads 0. A mailbox write of 55H always restarts the sequence at its first step.
- R5: The supported codes are 0CH (read), 0EH (program), 0BH (sector erase) and 08H (option program). Code 08H is supported only when the address-high register holds E0H. Any other code is ignored and bit 7 reads 0.
- R6: Bit 7 reads 0 while a command runs. `cpu_hold` stays high until `fl_done` is seen. On that clock edge `cpu_hold` falls and bit 7 becomes 1.
- R7: On completion of a read (0CH), the mailbox takes `fl_rdata` when `fl_locked` is 0. When `fl_locked` is 1, the mailbox keeps its previous contents.
- R8: Bus writes made while `cpu_hold` is high change no register and no sequence state.
- R9: `bus_rdata` returns the registers without delay: offset 0 as {bit7, enable, 000000b}, offset 1 as the last command code written, and offsets 2, 3 and 4 as written. The key registers and offset 7 read 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cpu_hold | output | 1 | Processor stall while a command runs |
| fl_start | output | 1 | One-cycle command start to the array |
| fl_op | output | 8 | Command code |
| fl_addr | output | 16 | Flash address |
| fl_wdata | output | 8 | Mailbox byte sent with the command |
| fl_done | input | 1 | One-cycle completion from the array |
| fl_rdata | input | 8 | Read data from the array |
| fl_locked | input | 1 | Target of the read is locked |

## Verification
The main function is tried with a correct unlock sequence, and with sequences that fail in different ways. A clean sequence checks that launch happens with the right opcode, address and data. A sequence with the enable clear, one with a wrong second key, one with a foreign write between the keys, and one restarted by a second 55H show whether the sequencer really tracks order and value rather than just counting writes. Unsupported codes, and the option code with and without the E0H page, separate the decode from the unlock. Reads to unlocked and to locked addresses, and writes issued during a stall, show whether the mailbox and the registers change only when they should.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_CFG  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CMD  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_MBOX = 3'd2;
  localparam logic [REG_AW-1:0] OFS_ADL  = 3'd3;
  localparam logic [REG_AW-1:0] OFS_ADH  = 3'd4;
  localparam logic [REG_AW-1:0] OFS_KEY1 = 3'd5;
  localparam logic [REG_AW-1:0] OFS_KEY2 = 3'd6;

  localparam int CFG_EN_BIT   = 6;
  localparam int CFG_DONE_BIT = 7;

  localparam logic [7:0] OP_READ     = 8'h0C;
  localparam logic [7:0] OP_PROG     = 8'h0E;
  localparam logic [7:0] OP_SECT     = 8'h0B;
  localparam logic [7:0] OP_OPTION   = 8'h08;
  localparam logic [7:0] OPTION_PAGE = 8'hE0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MBOX  = 2'd1,
    ST_KEY1  = 2'd2,
    ST_ARMED = 2'd3
  } unlock_step_t;
endpackage

// File: rtl/fcu_seq.sv
module fcu_seq
  import fcu_pkg::*;
#(
  parameter int          BYTE_W     = 8,
  parameter logic [7:0]  KEY_MBOX   = 8'h55,
  parameter logic [7:0]  KEY_FIRST  = 8'hA2,
  parameter logic [7:0]  KEY_SECOND = 8'hDF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic              armed
);
  unlock_step_t step_q, step_d;

  always_comb begin
    step_d = step_q;
    if (wr_ok) begin
      step_d = ST_IDLE;
      unique case (addr)
        OFS_MBOX: if (wdata == KEY_MBOX) step_d = ST_MBOX;
        OFS_KEY1: if (step_q == ST_MBOX && wdata == KEY_FIRST) step_d = ST_KEY1;
        OFS_KEY2: if (step_q == ST_KEY1 && wdata == KEY_SECOND) step_d = ST_ARMED;
        default:  step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  assign armed = (step_q == ST_ARMED);
endmodule

// File: rtl/fcu_decode.sv
module fcu_decode
  import fcu_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter bit HAS_OPTION = 1'b1
) (
  input  logic [BYTE_W-1:0] op,
  input  logic [BYTE_W-1:0] adh,
  output logic              ok
);
  logic base_ok;
  logic opt_ok;

  assign base_ok = (op == OP_READ) || (op == OP_PROG) || (op == OP_SECT);

  generate
    if (HAS_OPTION) begin : g_opt
      assign opt_ok = (op == OP_OPTION) && (adh == OPTION_PAGE);
    end else begin : g_noopt
      assign opt_ok = 1'b0;
    end
  endgenerate

  assign ok = base_ok || opt_ok;
endmodule

// File: rtl/fcu_exec.sv
module fcu_exec
  import fcu_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int FL_AW = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_code,
  input  logic              armed,
  input  logic              en,
  input  logic              code_ok,
  input  logic [BYTE_W-1:0] adl,
  input  logic [BYTE_W-1:0] adh,
  input  logic [BYTE_W-1:0] mbox,
  input  logic              fl_done,
  input  logic              fl_locked,
  output logic              busy,
  output logic              status,
  output logic              start,
  output logic [BYTE_W-1:0] op,
  output logic [FL_AW-1:0]  faddr,
  output logic [BYTE_W-1:0] fwdata,
  output logic              mbox_ld
);
  logic finish;
  logic launch;

  assign finish  = busy && fl_done && !start;
  assign launch  = cmd_wr && !busy && armed && en && code_ok;
  assign mbox_ld = finish && (op == OP_READ) && !fl_locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      status <= 1'b0;
      start  <= 1'b0;
      op     <= '0;
      faddr  <= '0;
      fwdata <= '0;
    end else begin
      start <= 1'b0;
      if (finish) begin
        busy   <= 1'b0;
        status <= 1'b1;
      end else if (launch) begin
        busy   <= 1'b1;
        start  <= 1'b1;
        status <= 1'b0;
        op     <= cmd_code;
        faddr  <= {adh, adl};
        fwdata <= mbox;
      end else if (cmd_wr && !busy) begin
        status <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcu_regs.sv
module fcu_regs
  import fcu_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic [REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mbox_ld,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              status,
  output logic              en,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] mbox_q,
  output logic [BYTE_W-1:0] adl_q,
  output logic [BYTE_W-1:0] adh_q,
  output logic [BYTE_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en     <= 1'b0;
      cmd_q  <= '0;
      mbox_q <= '0;
      adl_q  <= '0;
      adh_q  <= '0;
    end else begin
      if (mbox_ld) mbox_q <= ld_data;
      if (wr_ok) begin
        unique case (addr)
          OFS_CFG:  en     <= wdata[CFG_EN_BIT];
          OFS_CMD:  cmd_q  <= wdata;
          OFS_MBOX: mbox_q <= wdata;
          OFS_ADL:  adl_q  <= wdata;
          OFS_ADH:  adh_q  <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      OFS_CFG: begin
        rdata[CFG_DONE_BIT] = status;
        rdata[CFG_EN_BIT]   = en;
      end
      OFS_CMD:  rdata = cmd_q;
      OFS_MBOX: rdata = mbox_q;
      OFS_ADL:  rdata = adl_q;
      OFS_ADH:  rdata = adh_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/fcu_unlock_ctrl.sv
module fcu_unlock_ctrl
  import fcu_pkg::*;
#(
  parameter int         BYTE_W     = 8,
  parameter logic [7:0] KEY_MBOX   = 8'h55,
  parameter logic [7:0] KEY_FIRST  = 8'hA2,
  parameter logic [7:0] KEY_SECOND = 8'hDF,
  parameter bit         HAS_OPTION = 1'b1,
  localparam int        FL_AW      = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              cpu_hold,
  output logic              fl_start,
  output logic [BYTE_W-1:0] fl_op,
  output logic [FL_AW-1:0]  fl_addr,
  output logic [BYTE_W-1:0] fl_wdata,
  input  logic              fl_done,
  input  logic [BYTE_W-1:0] fl_rdata,
  input  logic              fl_locked
);
  logic              busy_w;
  logic              wr_ok_w;
  logic              cmd_wr_w;
  logic              armed_w;
  logic              en_w;
  logic              code_ok_w;
  logic              status_w;
  logic              mbox_ld_w;
  logic [BYTE_W-1:0] cmd_w;
  logic [BYTE_W-1:0] mbox_w;
  logic [BYTE_W-1:0] adl_w;
  logic [BYTE_W-1:0] adh_w;

  assign wr_ok_w  = bus_wr && !busy_w;
  assign cmd_wr_w = wr_ok_w && (bus_addr == OFS_CMD);
  assign cpu_hold = busy_w;

  fcu_seq #(
    .BYTE_W(BYTE_W), .KEY_MBOX(KEY_MBOX),
    .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_seq (
    .clk(clk), .rst(rst), .wr_ok(wr_ok_w), .addr(bus_addr),
    .wdata(bus_wdata), .armed(armed_w)
  );

  fcu_decode #(.BYTE_W(BYTE_W), .HAS_OPTION(HAS_OPTION)) u_dec (
    .op(bus_wdata), .adh(adh_w), .ok(code_ok_w)
  );

  fcu_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_ok(wr_ok_w), .addr(bus_addr),
    .wdata(bus_wdata), .mbox_ld(mbox_ld_w), .ld_data(fl_rdata),
    .status(status_w), .en(en_w), .cmd_q(cmd_w), .mbox_q(mbox_w),
    .adl_q(adl_w), .adh_q(adh_w), .rdata(bus_rdata)
  );

  fcu_exec #(.BYTE_W(BYTE_W)) u_exec (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr_w), .cmd_code(bus_wdata),
    .armed(armed_w), .en(en_w), .code_ok(code_ok_w),
    .adl(adl_w), .adh(adh_w), .mbox(mbox_w),
    .fl_done(fl_done), .fl_locked(fl_locked),
    .busy(busy_w), .status(status_w), .start(fl_start),
    .op(fl_op), .faddr(fl_addr), .fwdata(fl_wdata), .mbox_ld(mbox_ld_w)
  );

  logic unused_cmd;
  assign unused_cmd = ^cmd_w;
endmodule

// File: rtl/fcu_unlock_chk.sv
module fcu_unlock_chk
  import fcu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic              cpu_hold,
  input logic              fl_start,
  input logic              fl_done,
  input logic              status,
  input logic              en,
  input logic              armed,
  input logic [7:0]        adl
);
  logic cmd_try;
  assign cmd_try = bus_wr && (bus_addr == OFS_CMD) && !cpu_hold;

  assert_start_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    fl_start |=> !fl_start);

  assert_start_with_hold_R3: assert property (@(posedge clk) disable iff (rst)
    fl_start |-> (cpu_hold && !$past(cpu_hold)));

  assert_hold_until_done_R6: assert property (@(posedge clk) disable iff (rst)
    (cpu_hold && !fl_done) |=> cpu_hold);

  assert_done_sets_status_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_hold) |-> status);

  assert_disabled_no_launch_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_try && !en) |=> (!fl_start && !status));

  assert_unarmed_no_launch_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_try && !armed) |=> !fl_start);

  assert_hold_blocks_writes_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_hold |=> $stable(adl));
endmodule

bind fcu_unlock_ctrl fcu_unlock_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cpu_hold(cpu_hold), .fl_start(fl_start), .fl_done(fl_done),
  .status(status_w), .en(en_w), .armed(armed_w), .adl(adl_w)
);

// File: tb/fcu_unlock_ctrl_bench.sv
module fcu_unlock_ctrl_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        cpu_hold, fl_start;
  logic [7:0]  fl_op, fl_wdata;
  logic [15:0] fl_addr;
  logic        fl_done = 1'b0;
  logic [7:0]  fl_rdata = 8'h00;
  logic        fl_locked = 1'b0;

  fcu_unlock_ctrl u_fcu_unlock_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_hold(cpu_hold),
    .fl_start(fl_start), .fl_op(fl_op), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_done(fl_done), .fl_rdata(fl_rdata),
    .fl_locked(fl_locked)
  );

  int total = 0;
  int bad = 0;
  int starts = 0;
  bit ended = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model, updated on each rising edge
  bit        m_en, m_stat, m_hold, m_start;
  int        m_step;
  logic [7:0] m_cmd, m_dat, m_adl, m_adh, m_op, m_wd;
  logic [15:0] m_addr;

  function automatic bit supported(logic [7:0] c, logic [7:0] hi);
    return (c == 8'h0C) || (c == 8'h0E) || (c == 8'h0B) ||
           (c == 8'h08 && hi == 8'hE0);
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return {m_stat, m_en, 6'b0};
      3'd1: return m_cmd;
      3'd2: return m_dat;
      3'd3: return m_adl;
      3'd4: return m_adh;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    bit ns;
    ns = 0;
    if (rst) begin
      m_en = 0; m_stat = 0; m_hold = 0; m_step = 0;
      m_cmd = 0; m_dat = 0; m_adl = 0; m_adh = 0;
      m_op = 0; m_wd = 0; m_addr = 0;
    end else if (m_hold) begin
      if (fl_done && !m_start) begin
        m_hold = 0;
        m_stat = 1;
        if (m_op == 8'h0C && !fl_locked) m_dat = fl_rdata;
      end
    end else if (bus_wr) begin
      case (bus_addr)
        3'd0: begin m_en = bus_wdata[6]; m_step = 0; end
        3'd2: begin m_dat = bus_wdata; m_step = (bus_wdata == 8'h55) ? 1 : 0; end
        3'd3: begin m_adl = bus_wdata; m_step = 0; end
        3'd4: begin m_adh = bus_wdata; m_step = 0; end
        3'd5: m_step = (m_step == 1 && bus_wdata == 8'hA2) ? 2 : 0;
        3'd6: m_step = (m_step == 2 && bus_wdata == 8'hDF) ? 3 : 0;
        3'd1: begin
          m_cmd = bus_wdata;
          m_stat = 0;
          if (m_step == 3 && m_en && supported(bus_wdata, m_adh)) begin
            m_hold = 1; ns = 1; m_op = bus_wdata;
            m_addr = {m_adh, m_adl}; m_wd = m_dat;
          end
          m_step = 0;
        end
        default: m_step = 0;
      endcase
    end
    m_start = ns;
  end

  // per-cycle comparison, half a period after the edge
  always @(negedge clk) begin
    if (!rst && !ended) begin
      check("R6 cpu_hold", {31'b0, cpu_hold}, {31'b0, m_hold});
      check("R3 fl_start", {31'b0, fl_start}, {31'b0, m_start});
      if (m_start) begin
        check("R3 fl_op", {24'b0, fl_op}, {24'b0, m_op});
        check("R3 fl_addr", {16'b0, fl_addr}, {16'b0, m_addr});
        check("R3 fl_wdata", {24'b0, fl_wdata}, {24'b0, m_wd});
      end
      check("R9 bus_rdata", {24'b0, bus_rdata}, {24'b0, exp_rd(bus_addr)});
      if (fl_start) starts++;
    end
  end

  // array model: done four cycles after start; addresses with bit 15 set are locked
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(posedge clk); #1;
      fl_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          fl_done   = 1'b1;
          fl_rdata  = fl_addr[7:0] ^ 8'h5A;
          fl_locked = fl_addr[15];
        end
      end
      if (fl_start) cnt = 4;
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(posedge clk); #1;
    bus_addr = a;
    #2 v = bus_rdata;
  endtask

  task automatic unlock();
    wr(3'd2, 8'h55); wr(3'd5, 8'hA2); wr(3'd6, 8'hDF);
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 50 && cpu_hold; n++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int s0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    rd(3'd0, v); check("R1 cfg after reset", v, 8'h00);
    check("R1 hold after reset", {31'b0, cpu_hold}, 0);

    // command with a clean sequence
    wr(3'd0, 8'h40); wr(3'd3, 8'h34); wr(3'd4, 8'h12);
    unlock(); wr(3'd1, 8'h0E);
    rd(3'd0, v); check("R6 status low while busy", v, 8'h40);
    check("R3 op at launch", {24'b0, fl_op}, 8'h0E);
    check("R3 addr at launch", {16'b0, fl_addr}, 16'h1234);
    check("R3 data at launch", {24'b0, fl_wdata}, 8'h55);
    wait_idle(); rd(3'd0, v); check("R6 status after done", v, 8'hC0);

    // enable clear
    wr(3'd0, 8'h00); s0 = starts;
    unlock(); wr(3'd1, 8'h0E); repeat (3) @(posedge clk);
    rd(3'd0, v); check("R2 ignored when disabled", v, 8'h00);
    check("R2 no start when disabled", starts, s0);

    // wrong second key
    wr(3'd0, 8'h40); unlock(); wr(3'd1, 8'h0B); wait_idle();
    wr(3'd2, 8'h55); wr(3'd5, 8'hA2); wr(3'd6, 8'h11); wr(3'd1, 8'h0B);
    rd(3'd0, v); check("R4 wrong key ignored", v, 8'h40);
    // foreign write between keys
    unlock(); wr(3'd1, 8'h0B); wait_idle();
    wr(3'd2, 8'h55); wr(3'd5, 8'hA2); wr(3'd3, 8'h34); wr(3'd6, 8'hDF); wr(3'd1, 8'h0B);
    rd(3'd0, v); check("R4 interleaved write ignored", v, 8'h40);
    // keys before mailbox preset
    wr(3'd5, 8'hA2); wr(3'd6, 8'hDF); wr(3'd1, 8'h0B);
    rd(3'd0, v); check("R4 no preset ignored", v, 8'h40);
    // restart with a second preset
    wr(3'd2, 8'h55); wr(3'd5, 8'hA2); unlock(); wr(3'd1, 8'h0B); wait_idle();
    rd(3'd0, v); check("R4 restart accepted", v, 8'hC0);

    // decode
    unlock(); wr(3'd1, 8'h3C);
    rd(3'd0, v); check("R5 unknown code ignored", v, 8'h40);
    unlock(); wr(3'd1, 8'h08);
    rd(3'd0, v); check("R5 option without page ignored", v, 8'h40);
    wr(3'd4, 8'hE0); unlock(); wr(3'd1, 8'h08);
    check("R5 option addr", {16'b0, fl_addr}, 16'hE034);
    wait_idle(); rd(3'd0, v); check("R5 option completes", v, 8'hC0);

    // reads: unlocked then locked
    wr(3'd4, 8'h01); wr(3'd3, 8'h20); unlock(); wr(3'd1, 8'h0C); wait_idle();
    rd(3'd2, v); check("R7 unlocked read loads mailbox", v, 8'h7A);
    wr(3'd4, 8'h81); unlock(); wr(3'd1, 8'h0C); wait_idle();
    rd(3'd2, v); check("R7 locked read keeps mailbox", v, 8'h55);
    rd(3'd0, v); check("R7 locked read completes", v, 8'hC0);

    // writes during the stall
    wr(3'd3, 8'h34); unlock(); wr(3'd1, 8'h0E);
    wr(3'd3, 8'hFF); wr(3'd0, 8'h00);
    wait_idle();
    rd(3'd3, v); check("R8 addr low unchanged", v, 8'h34);
    rd(3'd0, v); check("R8 cfg unchanged", v, 8'hC0);

    // read-back map
    rd(3'd1, v); check("R9 command readback", v, 8'h0E);
    rd(3'd5, v); check("R9 key reads zero", v, 8'h00);
    rd(3'd7, v); check("R9 spare reads zero", v, 8'h00);

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule